// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers level-sensitive interrupt requests from on-chip peripherals and drives one interrupt line towards each CPU. Every CPU owns a private bank of enable words. Software routes a source to a CPU by setting the matching bit in that CPU's bank. A CPU's line is raised while any source that is enabled in its bank is active. The block applies no priority, no vectoring, no edge detection and no polarity control. Software finds the pending sources by reading every status word of its bank.

Registers are reached through a plain read/write port with byte addresses; bits [1:0] of the address are ignored. Banks sit back to back, one per CPU, each `NUM_SRC/4` bytes long. Each bank holds its enable words followed by its status words. Inside each area the words are stored in reverse order, so the highest-numbered word is at the lowest address. Enables can only be changed by writing a whole 32-bit word, so software masks and unmasks a single source with read-modify-write.

Top module: `percpu_irq_agg`

## Requirements
- R1: `NUM_SRC` takes 32, 64 or 128, giving NW = 1, 2 or 4 words of 32 sources. Word w carries sources 32w..32w+31, with source 32w+b at bit b.
- R2: After reset every enable bit is 0 and every `irq_o` bit is 0.
- R3: The enable word w of CPU c sits at byte address c·8·NW + 4·(NW−1−w). A write stores all 32 bits of `wdata_i`, and a read returns the stored word.
- R4: The status word w of CPU c sits at byte address c·8·NW + 4·NW + 4·(NW−1−w). A read returns `irq_i` as sampled at the clock edge before the read edge.
- R5: Writes to status addresses change no enable bit and no other state.
- R6: `irq_o[c]` is registered. It is 1 in the cycle after an edge at which some enabled bit of bank c and the matching sampled source were both 1, and 0 otherwise.
- R7: Banks are independent: a write to bank c changes only bank c, and `irq_o[c]` depends only on bank c's enables.
- R8: Reads of addresses at or above NUM_CPU·8·NW return 0, and writes to those addresses have no effect.
- R9: Read data appears on `rdata_o` in the cycle after `rd_en_i` is sampled high. `rdata_o` is 0 in any cycle that does not follow a read.
- R10: Inputs are levels: when a source drops, its CPU line falls without any software action, two edges after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Level interrupt requests from peripherals |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | NUM_CPU | Interrupt line per CPU |

## Verification
A read returns data one edge after its strobe. An enable write reaches `irq_o` one edge later. A change on `irq_i` is first captured into the status words and reaches `irq_o` one edge after that, two edges in total. The bench keeps a behavioural model that advances on each rising edge using the pre-edge inputs and the pre-edge model state, which gives exactly these delays. Both outputs are compared with the model at every falling edge, and inputs are only changed at falling edges, so every sample lands half a cycle after the edge at which the result is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic       valid;
    logic       is_status;
    logic [7:0] bank;
    logic [1:0] word;
  } dec_t;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam int NW      = NUM_SRC / WORD_W;
  localparam int BANK_SH = $clog2(NW * 8);
  localparam int SLOT_W  = BANK_SH - 2;

  logic [SLOT_W-1:0]        slot;
  logic [ADDR_W-BANK_SH-1:0] bank_raw;
  int                        s_idx;
  int                        w_idx;

  assign slot     = addr_i[BANK_SH-1:2];
  assign bank_raw = addr_i[ADDR_W-1:BANK_SH];

  always_comb begin
    s_idx           = int'(slot);
    dec_o.valid     = int'(bank_raw) < NUM_CPU;
    dec_o.is_status = s_idx >= NW;
    // reversed word order inside each area
    w_idx           = dec_o.is_status ? (2 * NW - 1 - s_idx) : (NW - 1 - s_idx);
    dec_o.word      = 2'(w_idx);
    dec_o.bank      = 8'(bank_raw);
  end
endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [1:0]         word_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic               irq_o
);
  localparam int NW = NUM_SRC / WORD_W;

  logic [NW-1:0][WORD_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (wr_i && word_i == 2'(w)) en_q[w] <= wdata_i;
      end
    end
  end

  assign en_o = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(en_o & src_i);
  end
endmodule

// File: rtl/percpu_irq_agg.sv
module percpu_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic [NUM_CPU-1:0] irq_o
);
  localparam int NW = NUM_SRC / WORD_W;

  dec_t                        dec;
  logic [NUM_SRC-1:0]          src_q;
  logic [NUM_CPU*NUM_SRC-1:0]  en_flat;
  logic [WORD_W-1:0]           rd_d;

  irq_addr_dec #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= irq_i;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic wr_c;
    assign wr_c = wr_en_i && dec.valid && !dec.is_status && dec.bank == 8'(c);
    irq_cpu_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_c),
      .word_i  (dec.word),
      .wdata_i (wdata_i),
      .src_i   (src_q),
      .en_o    (en_flat[c*NUM_SRC +: NUM_SRC]),
      .irq_o   (irq_o[c])
    );
  end

  always_comb begin
    rd_d = '0;
    if (rd_en_i && dec.valid) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        for (int w = 0; w < NW; w++) begin
          if (dec.bank == 8'(c) && dec.word == 2'(w))
            rd_d = dec.is_status ? src_q[w*WORD_W +: WORD_W]
                                 : en_flat[c*NUM_SRC + w*WORD_W +: WORD_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_SRC-1:0]         irq_i,
  input logic                       rd_en_i,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [31:0]                rdata_o,
  input logic [NUM_CPU-1:0]         irq_o,
  input logic [NUM_SRC-1:0]         src_q,
  input logic [NUM_CPU*NUM_SRC-1:0] en_flat
);
  localparam int BANK_B  = NUM_SRC / 4;
  localparam int TOTAL_B = NUM_CPU * BANK_B;

  logic in_range, at_status;
  assign in_range  = int'(addr_i) < TOTAL_B;
  assign at_status = in_range && (int'(addr_i) % BANK_B) >= BANK_B / 2;

  // R4
  stat_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> src_q == $past(irq_i));

  // R5
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && at_status |=> $stable(en_flat));

  // R8
  oor_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !in_range |=> rdata_o == '0);

  // R9
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);

  // R2
  no_en_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_flat == '0 |=> irq_o == '0);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    // R6
    irq_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |(en_flat[c*NUM_SRC +: NUM_SRC] & src_q) |=> irq_o[c]);
    // R6
    irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|(en_flat[c*NUM_SRC +: NUM_SRC] & src_q)) |=> !irq_o[c]);
  end
endmodule

bind percpu_irq_agg irq_agg_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_i   (irq_i),
  .rd_en_i (rd_en_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .src_q   (src_q),
  .en_flat (en_flat)
);

// File: tb/sim_percpu_irq_agg.sv
`timescale 1ns/1ps
module sim_percpu_irq_agg;
  localparam int NUM_SRC = 64;
  localparam int NUM_CPU = 2;
  localparam int ADDR_W  = 8;
  localparam int NW      = NUM_SRC / 32;
  localparam int BANK_B  = NW * 8;
  localparam int TOTAL_B = NUM_CPU * BANK_B;

  logic               clk = 0;
  logic               rst_n = 0;
  logic [NUM_SRC-1:0] irq_i = '0;
  logic               rd_en = 0, wr_en = 0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [31:0]        wdata = '0;
  logic [31:0]        rdata;
  logic [NUM_CPU-1:0] irq_o;

  int total = 0, bad = 0;
  string phase = "R2";

  percpu_irq_agg #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_i), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  // reference model
  logic [31:0]        m_en [NUM_CPU][NW];
  logic [NUM_SRC-1:0] m_src;
  logic [NUM_CPU-1:0] m_irq;
  logic [31:0]        m_rd;
  string              m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++) for (int w = 0; w < NW; w++) m_en[c][w] = 0;
      m_src = '0; m_irq = '0; m_rd = 0; m_tag = "R9";
    end else begin
      int a, bk, slot, wd;
      logic [NUM_CPU-1:0] nirq;
      logic [31:0] nrd;
      string ntag;
      for (int c = 0; c < NUM_CPU; c++) begin
        nirq[c] = 0;
        for (int s = 0; s < NUM_SRC; s++)
          if (m_en[c][s/32][s%32] && m_src[s]) nirq[c] = 1;
      end
      a = int'(addr);
      bk = a / BANK_B; slot = (a % BANK_B) / 4;
      nrd = 0; ntag = "R9";
      if (rd_en) begin
        if (a >= TOTAL_B) ntag = "R8";
        else if (slot < NW) begin
          wd = NW - 1 - slot; nrd = m_en[bk][wd]; ntag = "R3";
        end else begin
          wd = 2 * NW - 1 - slot; nrd = m_src[wd*32 +: 32]; ntag = "R1 R4";
        end
      end
      if (wr_en && a < TOTAL_B && slot < NW) m_en[bk][NW-1-slot] = wdata;
      m_src = irq_i; m_irq = nirq; m_rd = nrd; m_tag = ntag;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (irq_o !== m_irq) begin
        bad++;
        $display("FAIL R6 phase=%s irq_o actual=%b expected=%b", phase, irq_o, m_irq);
      end
      total++;
      if (rdata !== m_rd) begin
        bad++;
        $display("FAIL %s phase=%s rdata actual=%h expected=%h", m_tag, phase, rdata, m_rd);
      end
    end
  end

  task automatic op(input bit r, input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = ADDR_W'(a); wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0);
  endtask

  function automatic int en_addr(int c, int w); return c * BANK_B + 4 * (NW - 1 - w); endfunction
  function automatic int st_addr(int c, int w); return c * BANK_B + 4 * NW + 4 * (NW - 1 - w); endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: explicit reset-state check
    total++;
    if (irq_o !== '0 || rdata !== '0) begin
      bad++; $display("FAIL R2 reset irq_o=%b rdata=%h expected 0", irq_o, rdata);
    end
    for (int a = 0; a < TOTAL_B; a += 4) op(1, 0, a, 0);
    idle(1);

    phase = "R3";
    op(0, 1, en_addr(0, 0), 32'h0000_0011);
    op(0, 1, en_addr(0, 1), 32'h8000_0002);
    op(1, 0, en_addr(0, 0), 0);
    op(1, 0, en_addr(0, 1), 0);
    idle(1);

    phase = "R4";
    irq_i = '0; irq_i[1] = 1; irq_i[63] = 1;
    idle(2);
    for (int w = 0; w < NW; w++) op(1, 0, st_addr(0, w), 0);
    idle(2);

    phase = "R7";
    op(0, 1, en_addr(1, 1), 32'h0000_0002);
    op(1, 0, en_addr(0, 1), 0);
    irq_i = '0; irq_i[33] = 1;
    idle(3);
    irq_i = '0; irq_i[4] = 1;
    idle(3);

    phase = "R10";
    irq_i = '0;
    idle(3);

    phase = "R5";
    op(0, 1, st_addr(0, 0), 32'hffff_ffff);
    op(0, 1, st_addr(1, 1), 32'hffff_ffff);
    for (int a = 0; a < TOTAL_B; a += 4) op(1, 0, a, 0);
    idle(1);

    phase = "R8";
    op(0, 1, TOTAL_B, 32'hffff_ffff);
    op(1, 0, TOTAL_B, 0);
    op(1, 0, 252, 0);
    for (int a = 0; a < TOTAL_B; a += 4) op(1, 0, a, 0);
    idle(1);

    phase = "R6";
    for (int i = 0; i < 3000; i++) begin
      int a;
      a = int'($urandom_range(0, TOTAL_B + 15)) & ~3;
      if ($urandom_range(0, 3) == 0) irq_i = {$urandom, $urandom};
      op($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a, $urandom);
    end
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule